// File: doc/BRIEF.md
# Gamma Correction Palette

This block sits in a display pixel path and remaps each colour channel of a 24-bit RGB pixel through a 256-entry table. Every entry holds one corrected byte for each of red, green and blue. Each incoming channel byte picks its own entry, and only that entry's matching channel field is used. The result is a per-channel transfer curve, such as a gamma curve, applied at one pixel per clock.

Host software fills and inspects the table through two registers. A pointer register selects an entry. A data port reads or writes that entry and then moves the pointer on by one, so a whole table loads as one burst of writes. A bypass control passes pixels through unchanged. The bypass control is set out of reset. Host and pixel logic run on one clock and share a single table port. When the host and the pixel stream collide, the host wins, and in lookup mode the pixel output repeats its last value for that clock.

Top module: `gamma_palette`

## Requirements
- R1: After reset the bypass control reads 1, the pointer reads 0, the pixel valid output is 0, the pixel data output is 0 and the host read data is 0.
- R2: Each host write stores the entry at the current pointer, and each data access moves the pointer on by one, modulo 256, so 255 is followed by 0.
- R3: A host read returns the entry at the pointer value before the increment, one clock after the read strobe. The host word places blue at bits 31:24, green at 23:16 and red at 15:8. Bits 7:0 read as zero and are ignored on a write.
- R4: Read and write strobes on consecutive clocks each advance the pointer by exactly one. A read and a write in the same clock count as one access: the read returns the old contents and the new value is stored.
- R5: Loading the pointer sets the entry used by the next data access, so non-consecutive entries can be reached.
- R6: With bypass at 0 and a valid pixel, one clock later the output holds red = table red field at the input red byte, green = table green field at the input green byte, and blue = table blue field at the input blue byte. The pixel bus places red at bits 23:16, green at 15:8 and blue at 7:0.
- R7: With bypass at 1, a valid pixel appears unchanged on the output one clock later.
- R8: In lookup mode, a clock with a host read or write keeps the pixel data output at its previous value, while the pixel valid output still follows the input.
- R9: In bypass mode, a host access does not disturb the pixel output, and the access still takes effect on the table.
- R10: The pixel valid output is the valid input delayed by one clock. The pixel data output holds its value while the valid input is low.
- R11: A bypass change takes effect for the pixel presented on the clock after the write. Pixels on both sides of the change keep the one-clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared host and pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the bypass control |
| cfg_bypass_d | input | 1 | New bypass value (1 = pass through, 0 = table lookup) |
| cfg_bypass_q | output | 1 | Current bypass control |
| hst_ptr_ld | input | 1 | Load strobe for the table pointer |
| hst_ptr_d | input | 8 | Pointer value to load |
| hst_ptr_q | output | 8 | Current table pointer |
| hst_rd | input | 1 | Data port read strobe |
| hst_wr | input | 1 | Data port write strobe |
| hst_wdata | input | 32 | Data port write word |
| hst_rdata | output | 32 | Data port read word |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_rgb_i | input | 24 | Input pixel |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Corrected or passed-through pixel |

## Verification
The table is filled with three different curves: red is the index XOR 5Ah, green is three times the index and blue is the inverted index. A lookup that swaps channels or shares one index between them therefore gives a wrong byte. The pixel vectors include all-zero, all-one, and pixels with three different channel bytes, which separate per-channel indexing from whole-pixel indexing. They also include bytes at the table ends, which expose off-by-one addressing. Host sequences mix single reads, back-to-back read and write, simultaneous read and write, and pointer loads near the 255-to-0 wrap. Collision and mode-switch sequences separate a held output from a fresh lookup, and a raw pass-through from a table result.

// File: rtl/gamma_palette_pkg.sv
package gamma_palette_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_RD   = 2'b01,
      ACC_WR   = 2'b10,
      ACC_RDWR = 2'b11
   } acc_e;

   function automatic acc_e acc_decode(input logic rd, input logic wr);
      return acc_e'({wr, rd});
   endfunction

   function automatic logic acc_busy(input acc_e a);
      return a != ACC_NONE;
   endfunction

   function automatic logic acc_writes(input acc_e a);
      return (a == ACC_WR) || (a == ACC_RDWR);
   endfunction

   function automatic logic acc_reads(input acc_e a);
      return (a == ACC_RD) || (a == ACC_RDWR);
   endfunction

endpackage

// File: rtl/gamma_palette_ptr.sv
module gamma_palette_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);

   // a load overrides the step; the access in that clock used the old pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld) begin
         ptr <= ld_val;
      end else if (step) begin
         ptr <= ptr + ADDR_W'(1);
      end
   end

endmodule

// File: rtl/gamma_palette_lane.sv
module gamma_palette_lane #(
   parameter int CH_W   = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CH_W-1:0]   wdata,
   output logic [CH_W-1:0]   rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [CH_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   // asynchronous read: a same-clock write is seen only after the edge
   assign rdata = mem[addr];

endmodule

// File: rtl/gamma_palette_out.sv
module gamma_palette_out #(
   parameter int PIX_W          = 24,
   parameter bit HOLD_IN_BYPASS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic             bypass,
   input  logic             host_busy,
   input  logic [PIX_W-1:0] lut_d,
   input  logic [PIX_W-1:0] raw_d,
   output logic             vld_o,
   output logic [PIX_W-1:0] dat_o
);

   logic take;

   generate
      if (HOLD_IN_BYPASS) begin : g_hold_all
         assign take = vld_i && !host_busy;
      end else begin : g_hold_lut
         assign take = vld_i && (bypass || !host_busy);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         dat_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (take) begin
            dat_o <= bypass ? raw_d : lut_d;
         end
      end
   end

endmodule

// File: rtl/gamma_palette.sv
module gamma_palette #(
   parameter int CH_W           = 8,
   parameter int N_CH           = 3,
   parameter int HOST_W         = 32,
   parameter bit BYPASS_RST     = 1'b1,
   parameter bit HOLD_IN_BYPASS = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic                 cfg_bypass_d,
   output logic                 cfg_bypass_q,
   input  logic                 hst_ptr_ld,
   input  logic [CH_W-1:0]      hst_ptr_d,
   output logic [CH_W-1:0]      hst_ptr_q,
   input  logic                 hst_rd,
   input  logic                 hst_wr,
   input  logic [HOST_W-1:0]    hst_wdata,
   output logic [HOST_W-1:0]    hst_rdata,
   input  logic                 pix_vld_i,
   input  logic [CH_W*N_CH-1:0] pix_rgb_i,
   output logic                 pix_vld_o,
   output logic [CH_W*N_CH-1:0] pix_rgb_o
);

   import gamma_palette_pkg::*;

   localparam int PIX_W  = CH_W * N_CH;
   localparam int ADDR_W = CH_W;
   localparam int PAD_W  = HOST_W - PIX_W;

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("gamma_palette: N_CH must be at least 1");
      end
      if (PAD_W < 1) begin : g_bad_host
         $error("gamma_palette: HOST_W must exceed CH_W*N_CH");
      end
   endgenerate

   acc_e              acc;
   logic              busy;
   logic [PIX_W-1:0]  lut_rd;
   logic [HOST_W-1:0] rd_word;
   logic              unused_pad;

   assign acc        = acc_decode(hst_rd, hst_wr);
   assign busy       = acc_busy(acc);
   assign unused_pad = ^hst_wdata[PAD_W-1:0];

   // bypass control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_bypass_q <= BYPASS_RST;
      end else if (cfg_we) begin
         cfg_bypass_q <= cfg_bypass_d;
      end
   end

   gamma_palette_ptr #(
      .ADDR_W (ADDR_W)
   ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (hst_ptr_ld),
      .ld_val (hst_ptr_d),
      .step   (busy),
      .ptr    (hst_ptr_q)
   );

   // one table lane per channel; pixel lane k sits at bits k*CH_W,
   // host lane k sits mirrored above the reserved low field
   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_lane
         localparam int HPOS = PAD_W + (N_CH - 1 - k) * CH_W;
         logic [ADDR_W-1:0] addr;
         logic [CH_W-1:0]   q;

         assign addr = busy ? hst_ptr_q : pix_rgb_i[k*CH_W +: CH_W];

         gamma_palette_lane #(
            .CH_W   (CH_W),
            .ADDR_W (ADDR_W)
         ) u_lane (
            .clk   (clk),
            .we    (acc_writes(acc)),
            .addr  (addr),
            .wdata (hst_wdata[HPOS +: CH_W]),
            .rdata (q)
         );

         assign lut_rd[k*CH_W +: CH_W] = q;
         assign rd_word[HPOS +: CH_W]  = q;
      end
   endgenerate

   assign rd_word[PAD_W-1:0] = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hst_rdata <= '0;
      end else if (acc_reads(acc)) begin
         hst_rdata <= rd_word;
      end
   end

   gamma_palette_out #(
      .PIX_W          (PIX_W),
      .HOLD_IN_BYPASS (HOLD_IN_BYPASS)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (pix_vld_i),
      .bypass    (cfg_bypass_q),
      .host_busy (busy),
      .lut_d     (lut_rd),
      .raw_d     (pix_rgb_i),
      .vld_o     (pix_vld_o),
      .dat_o     (pix_rgb_o)
   );

endmodule

// File: rtl/gamma_palette_chk.sv
module gamma_palette_chk #(
   parameter int CH_W   = 8,
   parameter int N_CH   = 3,
   parameter int HOST_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 hst_ptr_ld,
   input logic [CH_W-1:0]      hst_ptr_q,
   input logic                 hst_rd,
   input logic                 hst_wr,
   input logic [HOST_W-1:0]    hst_rdata,
   input logic                 cfg_bypass_q,
   input logic                 pix_vld_i,
   input logic [CH_W*N_CH-1:0] pix_rgb_i,
   input logic                 pix_vld_o,
   input logic [CH_W*N_CH-1:0] pix_rgb_o
);

   localparam int PAD_W = HOST_W - CH_W * N_CH;

   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((hst_rd || hst_wr) && !hst_ptr_ld) |=> hst_ptr_q == CH_W'($past(hst_ptr_q) + 1'b1));

   p_ptr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hst_rd && !hst_wr && !hst_ptr_ld) |=> $stable(hst_ptr_q));

   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hst_rdata[PAD_W-1:0] == '0);

   p_host_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass_q && (hst_rd || hst_wr)) |=> $stable(pix_rgb_o));

   p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bypass_q && pix_vld_i) |=> pix_rgb_o == $past(pix_rgb_i));

   p_vld_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_i |=> pix_vld_o);

   p_vld_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld_i |=> !pix_vld_o);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld_i |=> $stable(pix_rgb_o));

endmodule

bind gamma_palette gamma_palette_chk #(
   .CH_W   (CH_W),
   .N_CH   (N_CH),
   .HOST_W (HOST_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_ptr_ld   (hst_ptr_ld),
   .hst_ptr_q    (hst_ptr_q),
   .hst_rd       (hst_rd),
   .hst_wr       (hst_wr),
   .hst_rdata    (hst_rdata),
   .cfg_bypass_q (cfg_bypass_q),
   .pix_vld_i    (pix_vld_i),
   .pix_rgb_i    (pix_rgb_i),
   .pix_vld_o    (pix_vld_o),
   .pix_rgb_o    (pix_rgb_o)
);

// File: tb/sim_gamma_palette.sv
`timescale 1ns/1ps
module sim_gamma_palette;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_bypass_d, cfg_bypass_q;
   logic        hst_ptr_ld;
   logic [7:0]  hst_ptr_d, hst_ptr_q;
   logic        hst_rd, hst_wr;
   logic [31:0] hst_wdata, hst_rdata;
   logic        pix_vld_i, pix_vld_o;
   logic [23:0] pix_rgb_i, pix_rgb_o;

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0] mr [256];
   logic [7:0] mg [256];
   logic [7:0] mb [256];

   localparam logic [23:0] PIX_VEC [8] = '{
      24'h000000, 24'hFFFFFF, 24'h123456, 24'hFF00A5,
      24'h0180FE, 24'h7F7F7F, 24'hC33C99, 24'h5AA50F
   };

   always #2 clk = ~clk;

   gamma_palette u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_bypass_d (cfg_bypass_d),
      .cfg_bypass_q (cfg_bypass_q),
      .hst_ptr_ld   (hst_ptr_ld),
      .hst_ptr_d    (hst_ptr_d),
      .hst_ptr_q    (hst_ptr_q),
      .hst_rd       (hst_rd),
      .hst_wr       (hst_wr),
      .hst_wdata    (hst_wdata),
      .hst_rdata    (hst_rdata),
      .pix_vld_i    (pix_vld_i),
      .pix_rgb_i    (pix_rgb_i),
      .pix_vld_o    (pix_vld_o),
      .pix_rgb_o    (pix_rgb_o)
   );

   function automatic logic [31:0] word(input logic [7:0] i);
      return {mb[i], mg[i], mr[i], 8'h00};
   endfunction

   function automatic logic [23:0] lk(input logic [23:0] p);
      return {mr[p[23:16]], mg[p[15:8]], mb[p[7:0]]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock; returns at the falling edge where outputs are sampled
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_ptr(input logic [7:0] a);
      hst_ptr_ld = 1'b1; hst_ptr_d = a;
      tick();
      hst_ptr_ld = 1'b0;
   endtask

   task automatic host_rd();
      hst_rd = 1'b1;
      tick();
      hst_rd = 1'b0;
   endtask

   task automatic set_entry(input logic [7:0] i, input logic [7:0] r,
                            input logic [7:0] g, input logic [7:0] b);
      mr[i] = r; mg[i] = g; mb[i] = b;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0]  p;
      logic [31:0] old_w;
      rst_n = 1'b0;
      cfg_we = 1'b0; cfg_bypass_d = 1'b0;
      hst_ptr_ld = 1'b0; hst_ptr_d = '0;
      hst_rd = 1'b0; hst_wr = 1'b0; hst_wdata = '0;
      pix_vld_i = 1'b0; pix_rgb_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 bypass", {31'd0, cfg_bypass_q}, 32'd1);
      chk("R1 ptr", {24'd0, hst_ptr_q}, 32'd0);
      chk("R1 vld", {31'd0, pix_vld_o}, 32'd0);
      chk("R1 rgb", {8'd0, pix_rgb_o}, 32'd0);
      chk("R1 rdata", hst_rdata, 32'd0);

      // fill the table by burst, reserved byte nonzero
      load_ptr(8'h00);
      for (int i = 0; i < 256; i++) begin
         set_entry(8'(i), 8'(i) ^ 8'h5A, 8'(i * 3), ~8'(i));
         hst_wr = 1'b1;
         hst_wdata = {mb[i], mg[i], mr[i], 8'hA5};
         tick();
         if (i == 0) chk("R2 ptr after first write", {24'd0, hst_ptr_q}, 32'd1);
      end
      hst_wr = 1'b0;
      chk("R2 ptr wrap after fill", {24'd0, hst_ptr_q}, 32'd0);

      // R3 reads near the top, R2 wrap
      load_ptr(8'hFE);
      host_rd();
      chk("R3 read FE", hst_rdata, word(8'hFE));
      chk("R3 ptr after read", {24'd0, hst_ptr_q}, 32'h0FF);
      host_rd();
      chk("R3 read FF", hst_rdata, word(8'hFF));
      chk("R2 ptr wrap on read", {24'd0, hst_ptr_q}, 32'd0);
      host_rd();
      chk("R3 read 00 after wrap", hst_rdata, word(8'h00));

      // R4 back-to-back read, write, read
      load_ptr(8'h10);
      hst_rd = 1'b1;
      tick();
      chk("R4 rd 10", hst_rdata, word(8'h10));
      hst_rd = 1'b0; hst_wr = 1'b1;
      set_entry(8'h11, 8'hC1, 8'hC2, 8'hC3);
      hst_wdata = {8'hC3, 8'hC2, 8'hC1, 8'h00};
      tick();
      hst_wr = 1'b0; hst_rd = 1'b1;
      tick();
      hst_rd = 1'b0;
      chk("R4 rd 12", hst_rdata, word(8'h12));
      chk("R4 ptr after three", {24'd0, hst_ptr_q}, 32'h13);
      load_ptr(8'h11);
      host_rd();
      chk("R4 written entry 11", hst_rdata, word(8'h11));

      // R4 simultaneous read and write
      load_ptr(8'h20);
      old_w = word(8'h20);
      set_entry(8'h20, 8'h01, 8'h02, 8'h03);
      hst_rd = 1'b1; hst_wr = 1'b1;
      hst_wdata = {8'h03, 8'h02, 8'h01, 8'hFF};
      tick();
      hst_rd = 1'b0; hst_wr = 1'b0;
      chk("R4 rdwr returns old", hst_rdata, old_w);
      chk("R4 rdwr single step", {24'd0, hst_ptr_q}, 32'h21);
      load_ptr(8'h20);
      host_rd();
      chk("R4 rdwr stored new", hst_rdata, word(8'h20));

      // R5 non-consecutive access
      load_ptr(8'h40);
      host_rd();
      chk("R5 read 40", hst_rdata, word(8'h40));
      load_ptr(8'h07);
      host_rd();
      chk("R5 read 07", hst_rdata, word(8'h07));

      // lookup mode
      cfg_we = 1'b1; cfg_bypass_d = 1'b0;
      tick();
      cfg_we = 1'b0;
      chk("R6 bypass cleared", {31'd0, cfg_bypass_q}, 32'd0);

      // R6 vector table
      for (int i = 0; i < 8; i++) begin
         pix_vld_i = 1'b1; pix_rgb_i = PIX_VEC[i];
         tick();
         chk("R6 lookup", {8'd0, pix_rgb_o}, {8'd0, lk(PIX_VEC[i])});
         chk("R10 vld", {31'd0, pix_vld_o}, 32'd1);
      end

      // R8 host collision holds output
      pix_rgb_i = 24'h102030;
      tick();
      chk("R8 before collision", {8'd0, pix_rgb_o}, {8'd0, lk(24'h102030)});
      p = hst_ptr_q;
      pix_rgb_i = 24'hA0B0C0; hst_rd = 1'b1;
      tick();
      hst_rd = 1'b0;
      chk("R8 held", {8'd0, pix_rgb_o}, {8'd0, lk(24'h102030)});
      chk("R8 vld follows", {31'd0, pix_vld_o}, 32'd1);
      chk("R8 host read", hst_rdata, word(p));
      pix_rgb_i = 24'h0D0E0F;
      tick();
      chk("R8 resumes", {8'd0, pix_rgb_o}, {8'd0, lk(24'h0D0E0F)});

      // R10 invalid input holds
      pix_vld_i = 1'b0; pix_rgb_i = 24'h777777;
      tick();
      chk("R10 vld low", {31'd0, pix_vld_o}, 32'd0);
      chk("R10 data held", {8'd0, pix_rgb_o}, {8'd0, lk(24'h0D0E0F)});

      // R11 switch to bypass: current pixel still looked up
      pix_vld_i = 1'b1; pix_rgb_i = 24'h334455;
      cfg_we = 1'b1; cfg_bypass_d = 1'b1;
      tick();
      cfg_we = 1'b0;
      chk("R11 old mode lookup", {8'd0, pix_rgb_o}, {8'd0, lk(24'h334455)});
      pix_rgb_i = 24'h334455;
      tick();
      chk("R7 raw pass", {8'd0, pix_rgb_o}, 32'h334455);

      // R9 host write in bypass does not disturb the output
      p = hst_ptr_q;
      set_entry(p, 8'h9A, 8'h9B, 8'h9C);
      pix_rgb_i = 24'hABCDEF; hst_wr = 1'b1;
      hst_wdata = {8'h9C, 8'h9B, 8'h9A, 8'h00};
      tick();
      hst_wr = 1'b0;
      chk("R9 bypass unaffected", {8'd0, pix_rgb_o}, 32'hABCDEF);
      pix_vld_i = 1'b0;
      load_ptr(p);
      host_rd();
      chk("R9 write landed", hst_rdata, word(p));

      // R11 switch back to lookup
      pix_vld_i = 1'b1; pix_rgb_i = 24'h5566FF;
      cfg_we = 1'b1; cfg_bypass_d = 1'b0;
      tick();
      cfg_we = 1'b0;
      chk("R11 old mode raw", {8'd0, pix_rgb_o}, 32'h5566FF);
      pix_rgb_i = 24'h00FF80;
      tick();
      chk("R11 new mode lookup", {8'd0, pix_rgb_o}, {8'd0, lk(24'h00FF80)});
      pix_vld_i = 1'b0;
      tick();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule